// File: doc/BRIEF.md
# Sliced Vector Pipeline Issue Controller

This block steers instructions through a fixed-depth vector execution pipeline in which every instruction is cut into register slices. An accepted instruction sends its first slice into stage 0 in the same cycle. The block keeps that instruction as the single in-flight instruction and feeds one further slice per cycle, whenever the register scoreboard reports that the reads are clear. Slice tokens shift through the stages in lockstep. Tokens that produce a register result drop into a short writeback FIFO. The FIFO drains in order to the register file, one entry per cycle.

Any slice flagged as a memory access sends one request as it passes a chosen memory stage. A fixed number of stages further on, the whole pipeline waits until the reply for that slice has come back. A scalar source is read only with slice 0, and a scalar destination is written only by the final slice. Instructions retire along one of two paths. The writeback path retires an instruction when its last written slice drains from the FIFO. The direct path retires an instruction whose final slice leaves the last stage without writing anything.

Top module: `vpipe_issue_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all stages, the writeback FIFO and the in-flight state are empty, `iss_ready` is 1, and `stall`, `wb_valid`, `mem_req` and both retire strobes are 0.
- R2: The slice count is ceil(2^g × SLICES_PER_REG), where g = `iss_grp` is a signed log2 group multiplier (−3 to 3). This gives 1, 1, 2, 4, 8, 16 for g = −3…2 with the default of 4. Slice 0 issues in the accept cycle, and accept is `iss_valid & iss_ready & rd_ready`. Each further slice issues in order on a cycle with `rd_ready` high and `stall` low. `iss_ready` stays low until the last slice has issued.
- R3: With `wait_empty` = 0, a new instruction may be accepted as soon as no instruction is in flight and there is no stall. With `wait_empty` = 1, every stage must also be empty.
- R4: `slice_scl_rd` is 1 only together with slice 0 of an instruction that has a scalar source. A scalar destination produces exactly one writeback, from the final slice. A vector destination produces one writeback per slice.
- R5: With no stall, a writing slice issued in cycle c appears on `wb_valid` in cycle c+DEPTH+1, provided `wr_ready` is high.
- R6: The writeback FIFO holds at most WBQ_DEPTH entries. It drains at most one entry per cycle, in issue order, and only while `wr_ready` is high.
- R7: `stall` rises when the last stage holds a writing slice and the FIFO has no room. While `stall` is high, no stage shifts and no slice or instruction issues, but FIFO draining continues.
- R8: A memory slice raises `mem_req` exactly once. This happens in the first cycle the slice sits in stage MEM_STAGE, which is cycle c+MEM_STAGE+1 for a slice issued in cycle c.
- R9: A memory slice in stage MEM_STAGE+MEM_LAT with no reply recorded holds `stall` high. A `mem_rsp` pulse is credited to the oldest outstanding request, and the stall clears in the following cycle.
- R10: `ret_wb_valid` pulses when the entry of an instruction's final slice drains. `ret_dir_valid` pulses when a non-writing final slice leaves the last stage. Both may pulse in the same cycle, for different instructions.
- R11: Draining is resolved before the shift. A full FIFO that drains in the current cycle does not stall a writing slice in the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_empty | input | 1 | 1: accept only when all stages are empty |
| iss_valid | input | 1 | Instruction descriptor offered |
| iss_ready | output | 1 | Block can take an instruction |
| iss_tag | input | TAG_W | Instruction tag |
| iss_grp | input | 3 | Signed log2 group multiplier |
| iss_vec_wr | input | 1 | Every slice writes a vector register |
| iss_scl_rd | input | 1 | Instruction reads a scalar source |
| iss_scl_wr | input | 1 | Final slice writes a scalar destination |
| iss_mem | input | 1 | Every slice makes a memory access |
| rd_ready | input | 1 | Register reads of the next slice are clear |
| wr_ready | input | 1 | FIFO head destination is writable |
| slice_valid | output | 1 | A slice enters stage 0 this cycle |
| slice_tag | output | TAG_W | Tag of that slice |
| slice_idx | output | IDX_W | Index of that slice |
| slice_scl_rd | output | 1 | Scalar source read with this slice |
| wb_valid | output | 1 | FIFO head written this cycle |
| wb_tag | output | TAG_W | Tag of written entry |
| wb_idx | output | IDX_W | Slice index of written entry |
| mem_req | output | 1 | Memory request this cycle |
| mem_req_tag | output | TAG_W | Tag of requesting slice |
| mem_req_idx | output | IDX_W | Index of requesting slice |
| mem_rsp | input | 1 | Reply for the oldest outstanding request |
| stall | output | 1 | Pipeline frozen this cycle |
| ret_wb_valid | output | 1 | Retire through writeback |
| ret_wb_tag | output | TAG_W | Tag retired through writeback |
| ret_dir_valid | output | 1 | Retire straight from the last stage |
| ret_dir_tag | output | TAG_W | Tag retired directly |

## Verification
Two functions can fall in the same cycle: draining the writeback FIFO and a pipeline stall. They meet in two ways. A memory-stall test fills the FIFO while `wr_ready` is low, then raises `wr_ready` just as an unanswered memory slice reaches its check stage. The bench expects `stall` and `wb_valid` together, in a known order of tags. A second test keeps the FIFO full until a writing slice sits in the last stage. It then raises `wr_ready` and expects the drain to cancel the stall in that same cycle. A further test times a writeback retire and a direct retire of two instructions so that both land on one cycle, and checks both tags.

// File: rtl/vp_pkg.sv
package vp_pkg;
  parameter int TAG_W = 4;
  parameter int IDX_W = 6;

  // one slice token in a pipeline stage
  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             wr;
    logic             mem;
    logic             sent;
    logic             got;
  } slot_t;

  // one pending register write
  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] idx;
    logic             last;
  } wb_t;

  // ceil(2^g * spr) for a signed log2 group multiplier g
  function automatic logic [IDX_W:0] slice_total(input logic signed [2:0] g, input int spr);
    int gi;
    int n;
    gi = int'(g);
    if (gi >= 0) n = spr << gi;
    else         n = (spr + (1 << (-gi)) - 1) >> (-gi);
    return n[IDX_W:0];
  endfunction

  // a slice writes if the destination is a vector, or scalar and final
  function automatic logic slice_writes(input logic vec_wr, input logic scl_wr, input logic is_last);
    return vec_wr | (scl_wr & is_last);
  endfunction
endpackage

// File: rtl/vp_slice_seq.sv
module vp_slice_seq
  import vp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic [IDX_W:0]   acc_cnt,
  input  logic             acc_vec_wr,
  input  logic             acc_scl_wr,
  input  logic             acc_mem,
  input  logic             go,
  output logic             busy,
  output slot_t            ins
);
  logic [TAG_W-1:0] cur_tag;
  logic [IDX_W:0]   cur_cnt;
  logic [IDX_W-1:0] nxt_idx;
  logic             cur_vw, cur_sw, cur_mem;
  logic             ins_vld, lst;
  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   cnt;

  always_comb begin
    ins_vld = acc | (busy & go);
    idx     = acc ? '0 : nxt_idx;
    cnt     = acc ? acc_cnt : cur_cnt;
    lst     = ((IDX_W+1)'(idx) + 1'b1) == cnt;
    ins      = '0;
    ins.vld  = ins_vld;
    ins.tag  = acc ? acc_tag : cur_tag;
    ins.idx  = idx;
    ins.last = lst;
    ins.wr   = slice_writes(acc ? acc_vec_wr : cur_vw, acc ? acc_scl_wr : cur_sw, lst);
    ins.mem  = acc ? acc_mem : cur_mem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      nxt_idx <= '0;
      cur_tag <= '0;
      cur_cnt <= '0;
      cur_vw  <= 1'b0;
      cur_sw  <= 1'b0;
      cur_mem <= 1'b0;
    end else if (ins_vld) begin
      busy    <= !lst;
      nxt_idx <= idx + 1'b1;
      if (acc) begin
        cur_tag <= acc_tag;
        cur_cnt <= acc_cnt;
        cur_vw  <= acc_vec_wr;
        cur_sw  <= acc_scl_wr;
        cur_mem <= acc_mem;
      end
    end
  end
endmodule

// File: rtl/vp_wb_fifo.sv
module vp_wb_fifo
  import vp_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  wb_t           din,
  input  logic          wr_ok,
  output logic          drain,
  output logic          room,
  output wb_t           head,
  output logic [CW-1:0] count
);
  wb_t           ent [DEPTH];
  logic [PW-1:0] rp, wp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign drain = (count != '0) & wr_ok;
  assign room  = (count != CW'(DEPTH)) | drain;
  assign head  = ent[rp];

  always_ff @(posedge clk) begin
    if (push) ent[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (push)  wp <= step(wp);
      if (drain) rp <= step(rp);
      count <= count + CW'(push) - CW'(drain);
    end
  end
endmodule

// File: rtl/vp_stage_pipe.sv
module vp_stage_pipe
  import vp_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int MEM_STAGE = 1,
  parameter int MEM_LAT   = 2,
  localparam int CHK = MEM_STAGE + MEM_LAT
) (
  input  logic             clk,
  input  logic             rst,
  input  slot_t            ins,
  input  logic             wb_room,
  input  logic             rsp,
  output logic             stall,
  output logic             tail_go,
  output logic [TAG_W-1:0] tail_tag,
  output logic [IDX_W-1:0] tail_idx,
  output logic             tail_last,
  output logic             tail_wr,
  output logic             mem_req,
  output logic [TAG_W-1:0] mem_tag,
  output logic [IDX_W-1:0] mem_idx,
  output logic             empty
);
  slot_t st [DEPTH];
  slot_t nx [DEPTH];
  logic  stall_wb, stall_mem, adv, hit_ok;
  int    hit;

  assign stall_wb  = st[DEPTH-1].vld & st[DEPTH-1].wr & !wb_room;
  assign stall_mem = st[CHK].vld & st[CHK].mem & !st[CHK].got;
  assign stall     = stall_wb | stall_mem;
  assign adv       = !stall;

  assign tail_go   = adv & st[DEPTH-1].vld;
  assign tail_tag  = st[DEPTH-1].tag;
  assign tail_idx  = st[DEPTH-1].idx;
  assign tail_last = st[DEPTH-1].last;
  assign tail_wr   = st[DEPTH-1].wr;

  assign mem_req = st[MEM_STAGE].vld & st[MEM_STAGE].mem & !st[MEM_STAGE].sent;
  assign mem_tag = st[MEM_STAGE].tag;
  assign mem_idx = st[MEM_STAGE].idx;

  // oldest outstanding request sits in the highest stage
  always_comb begin
    hit_ok = 1'b0;
    hit    = 0;
    empty  = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (st[i].vld) empty = 1'b0;
      if (st[i].vld && st[i].mem && st[i].sent && !st[i].got) begin
        hit_ok = 1'b1;
        hit    = i;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) nx[i] = st[i];
    if (adv) begin
      nx[0] = ins;
      for (int i = 1; i < DEPTH; i++) nx[i] = st[i-1];
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (mem_req && i == MEM_STAGE + int'(adv)) nx[i].sent = 1'b1;
      if (rsp && hit_ok && i == hit + int'(adv)) nx[i].got = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) st[i] <= '0;
      else     st[i] <= nx[i];
    end
  end
endmodule

// File: rtl/vpipe_issue_ctrl.sv
module vpipe_issue_ctrl
  import vp_pkg::*;
#(
  parameter int DEPTH          = 4,
  parameter int SLICES_PER_REG = 4,
  parameter int WBQ_DEPTH      = 2,
  parameter int MEM_STAGE      = 1,
  parameter int MEM_LAT        = 2,
  localparam int WCW = $clog2(WBQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wait_empty,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic signed [2:0] iss_grp,
  input  logic              iss_vec_wr,
  input  logic              iss_scl_rd,
  input  logic              iss_scl_wr,
  input  logic              iss_mem,
  input  logic              rd_ready,
  input  logic              wr_ready,
  output logic              slice_valid,
  output logic [TAG_W-1:0]  slice_tag,
  output logic [IDX_W-1:0]  slice_idx,
  output logic              slice_scl_rd,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [IDX_W-1:0]  wb_idx,
  output logic              mem_req,
  output logic [TAG_W-1:0]  mem_req_tag,
  output logic [IDX_W-1:0]  mem_req_idx,
  input  logic              mem_rsp,
  output logic              stall,
  output logic              ret_wb_valid,
  output logic [TAG_W-1:0]  ret_wb_tag,
  output logic              ret_dir_valid,
  output logic [TAG_W-1:0]  ret_dir_tag
);
  // named internal events, visible to the bound checker
  logic             accept, busy, pipe_empty, wb_room, wb_push;
  logic             tail_go, tail_last, tail_wr;
  logic [TAG_W-1:0] tail_tag;
  logic [IDX_W-1:0] tail_idx;
  logic [WCW-1:0]   wbq_cnt;
  slot_t            ins;
  wb_t              wb_in, wb_head;

  assign iss_ready = !busy && !stall && (!wait_empty || pipe_empty);
  assign accept    = iss_valid && iss_ready && rd_ready;

  vp_slice_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .acc        (accept),
    .acc_tag    (iss_tag),
    .acc_cnt    (slice_total(iss_grp, SLICES_PER_REG)),
    .acc_vec_wr (iss_vec_wr),
    .acc_scl_wr (iss_scl_wr),
    .acc_mem    (iss_mem),
    .go         (rd_ready && !stall),
    .busy       (busy),
    .ins        (ins)
  );

  assign slice_valid  = ins.vld;
  assign slice_tag    = ins.tag;
  assign slice_idx    = ins.idx;
  assign slice_scl_rd = accept && iss_scl_rd;

  vp_stage_pipe #(
    .DEPTH     (DEPTH),
    .MEM_STAGE (MEM_STAGE),
    .MEM_LAT   (MEM_LAT)
  ) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .ins       (ins),
    .wb_room   (wb_room),
    .rsp       (mem_rsp),
    .stall     (stall),
    .tail_go   (tail_go),
    .tail_tag  (tail_tag),
    .tail_idx  (tail_idx),
    .tail_last (tail_last),
    .tail_wr   (tail_wr),
    .mem_req   (mem_req),
    .mem_tag   (mem_req_tag),
    .mem_idx   (mem_req_idx),
    .empty     (pipe_empty)
  );

  assign wb_push    = tail_go && tail_wr;
  assign wb_in.tag  = tail_tag;
  assign wb_in.idx  = tail_idx;
  assign wb_in.last = tail_last;

  vp_wb_fifo #(.DEPTH(WBQ_DEPTH)) u_wbq (
    .clk   (clk),
    .rst   (rst),
    .push  (wb_push),
    .din   (wb_in),
    .wr_ok (wr_ready),
    .drain (wb_valid),
    .room  (wb_room),
    .head  (wb_head),
    .count (wbq_cnt)
  );

  assign wb_tag        = wb_head.tag;
  assign wb_idx        = wb_head.idx;
  assign ret_wb_valid  = wb_valid && wb_head.last;
  assign ret_wb_tag    = wb_head.tag;
  assign ret_dir_valid = tail_go && tail_last && !tail_wr;
  assign ret_dir_tag   = tail_tag;
endmodule

// File: rtl/vpipe_issue_ctrl_chk.sv
module vpipe_issue_ctrl_chk #(
  parameter int IDX_W     = 6,
  parameter int WBQ_DEPTH = 2,
  parameter int CNT_W     = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_ready,
  input logic             slice_valid,
  input logic [IDX_W-1:0] slice_idx,
  input logic             slice_scl_rd,
  input logic             stall,
  input logic [CNT_W-1:0] wbq_cnt,
  input logic             wr_ready,
  input logic             wb_valid,
  input logic             mem_req,
  input logic             ret_dir_valid
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (iss_ready && !wb_valid && !mem_req && !stall));

  assert_no_slice_in_stall_R2: assert property (@(posedge clk) disable iff (rst)
    slice_valid |-> !stall);

  assert_scalar_first_R4: assert property (@(posedge clk) disable iff (rst)
    slice_scl_rd |-> (slice_valid && slice_idx == '0));

  assert_wbq_bound_R6: assert property (@(posedge clk) disable iff (rst)
    wbq_cnt <= CNT_W'(WBQ_DEPTH));

  assert_drain_in_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (stall && wbq_cnt != '0 && wr_ready) |-> wb_valid);

  assert_req_once_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && stall) |=> !mem_req);

  assert_dir_no_stall_R10: assert property (@(posedge clk) disable iff (rst)
    ret_dir_valid |-> !stall);
endmodule

bind vpipe_issue_ctrl vpipe_issue_ctrl_chk #(
  .IDX_W     (vp_pkg::IDX_W),
  .WBQ_DEPTH (WBQ_DEPTH),
  .CNT_W     (WCW)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .iss_ready     (iss_ready),
  .slice_valid   (slice_valid),
  .slice_idx     (slice_idx),
  .slice_scl_rd  (slice_scl_rd),
  .stall         (stall),
  .wbq_cnt       (wbq_cnt),
  .wr_ready      (wr_ready),
  .wb_valid      (wb_valid),
  .mem_req       (mem_req),
  .ret_dir_valid (ret_dir_valid)
);

// File: tb/tb_vpipe_issue_ctrl.sv
module tb_vpipe_issue_ctrl;
  localparam int D   = 4;
  localparam int SPR = 4;
  localparam int TW  = 4;
  localparam int IW  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wait_empty, iss_valid, iss_ready, iss_vec_wr, iss_scl_rd, iss_scl_wr, iss_mem;
  logic [TW-1:0] iss_tag;
  logic signed [2:0] iss_grp;
  logic rd_ready, wr_ready, slice_valid, slice_scl_rd, wb_valid, mem_req, mem_rsp, stall;
  logic [TW-1:0] slice_tag, wb_tag, mem_req_tag, ret_wb_tag, ret_dir_tag;
  logic [IW-1:0] slice_idx, wb_idx, mem_req_idx;
  logic ret_wb_valid, ret_dir_valid;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  int exp_q[$];
  int pend[16];
  bit m_busy = 0;
  int m_tag, m_next, m_n;
  int outstanding = 0, mem_exp = 0, mem_seen = 0;
  bit auto_rsp = 0;

  always #4 clk = ~clk;

  vpipe_issue_ctrl dut (
    .clk(clk), .rst(rst), .wait_empty(wait_empty), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_tag(iss_tag), .iss_grp(iss_grp), .iss_vec_wr(iss_vec_wr), .iss_scl_rd(iss_scl_rd),
    .iss_scl_wr(iss_scl_wr), .iss_mem(iss_mem), .rd_ready(rd_ready), .wr_ready(wr_ready),
    .slice_valid(slice_valid), .slice_tag(slice_tag), .slice_idx(slice_idx),
    .slice_scl_rd(slice_scl_rd), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_idx(wb_idx),
    .mem_req(mem_req), .mem_req_tag(mem_req_tag), .mem_req_idx(mem_req_idx), .mem_rsp(mem_rsp),
    .stall(stall), .ret_wb_valid(ret_wb_valid), .ret_wb_tag(ret_wb_tag),
    .ret_dir_valid(ret_dir_valid), .ret_dir_tag(ret_dir_tag)
  );

  // ceil(2^g * SPR) computed over eighths
  function automatic int exp_slices(int g);
    return (SPR * (1 << (g + 3)) + 7) / 8;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc_cnt);
    end
  endtask

  task automatic idle();
    iss_valid = 0; iss_tag = 0; iss_grp = 0; iss_vec_wr = 0; iss_scl_rd = 0;
    iss_scl_wr = 0; iss_mem = 0; rd_ready = 1; wr_ready = 1;
    mem_rsp = auto_rsp && outstanding > 0 && ($urandom % 3 == 0);
  endtask

  task automatic offer(int tag, int g, bit vw, bit sr, bit sw, bit mm);
    iss_valid = 1; iss_tag = TW'(tag); iss_grp = 3'(g);
    iss_vec_wr = vw; iss_scl_rd = sr; iss_scl_wr = sw; iss_mem = mm;
  endtask

  // independent model of slicing, writeback order and retirement
  task automatic observe();
    bit acc;
    int n;
    acc = iss_valid && iss_ready && rd_ready;
    if (acc) begin
      chk(!m_busy, "R2 accept while slicing", 1, 0);
      chk(slice_valid && slice_idx == 0 && slice_tag == iss_tag, "R2 slice0 on accept", slice_idx, 0);
      chk(slice_scl_rd == iss_scl_rd, "R4 scalar read with slice0", slice_scl_rd, iss_scl_rd);
      n = exp_slices(int'(iss_grp));
      for (int i = 0; i < n; i++)
        if (iss_vec_wr || (iss_scl_wr && i == n - 1)) exp_q.push_back(int'(iss_tag) * 64 + i);
      pend[iss_tag] = (iss_vec_wr || iss_scl_wr) ? 1 : 2;
      if (iss_mem) mem_exp += n;
      m_busy = n > 1; m_tag = int'(iss_tag); m_next = 1; m_n = n;
    end else if (m_busy) begin
      chk(!iss_ready, "R2 no accept while slicing", iss_ready, 0);
      chk(slice_valid == (rd_ready && !stall), "R2 slice gating", slice_valid, rd_ready && !stall);
      if (slice_valid) begin
        chk(slice_idx == m_next && slice_tag == m_tag, "R2 slice order", slice_idx, m_next);
        chk(!slice_scl_rd, "R4 no scalar read after slice0", slice_scl_rd, 0);
        m_next++;
        if (m_next == m_n) m_busy = 0;
      end
    end else chk(!slice_valid, "R2 no spurious slice", slice_valid, 0);
    if (wb_valid) begin
      chk(exp_q.size() > 0, "R6 writeback expected", 1, exp_q.size());
      if (exp_q.size() > 0) begin
        chk(int'(wb_tag) * 64 + int'(wb_idx) == exp_q[0], "R6 writeback order",
            int'(wb_tag) * 64 + int'(wb_idx), exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
    if (ret_wb_valid) begin
      chk(pend[ret_wb_tag] == 1, "R10 writeback retire", pend[ret_wb_tag], 1);
      pend[ret_wb_tag] = 0;
    end
    if (ret_dir_valid) begin
      chk(pend[ret_dir_tag] == 2, "R10 direct retire", pend[ret_dir_tag], 2);
      pend[ret_dir_tag] = 0;
    end
    if (mem_rsp) outstanding--;
    if (mem_req) begin outstanding++; mem_seen++; end
  endtask

  task automatic settle(); #1; observe(); endtask
  task automatic adv(); @(posedge clk); #1; cyc_cnt++; endtask
  task automatic flush(int n);
    for (int k = 0; k < n; k++) begin idle(); settle(); adv(); end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < 16; i++) pend[i] = 0;
    wait_empty = 0;
    idle();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1;
    // R1 reset state
    chk(iss_ready && !stall && !wb_valid && !mem_req && !slice_valid && !ret_wb_valid && !ret_dir_valid,
        "R1 reset idle", iss_ready, 1);
    adv();

    // R2/R3/R5: four-slice vector write, latency and re-ready
    for (int k = 0; k < 10; k++) begin
      idle();
      if (k == 0) offer(1, 0, 1, 0, 0, 0);
      settle();
      if (k == 0) chk(iss_ready, "R2 ready at start", iss_ready, 1);
      if (k == 2) chk(!iss_ready, "R2 busy while slicing", iss_ready, 0);
      if (k == 4) chk(iss_ready, "R3 pipelined ready with stages busy", iss_ready, 1);
      if (k == 4) chk(!wb_valid, "R5 no early writeback", wb_valid, 0);
      if (k == 5) chk(wb_valid && wb_idx == 0 && wb_tag == 1, "R5 writeback latency", wb_valid, 1);
      if (k == 8) chk(ret_wb_valid && ret_wb_tag == 1, "R10 retire on last entry", ret_wb_valid, 1);
      adv();
    end
    flush(4);

    // R4: scalar source and scalar destination, two slices
    for (int k = 0; k < 8; k++) begin
      idle();
      if (k == 0) offer(2, -1, 0, 1, 1, 0);
      settle();
      if (k == 0) chk(slice_scl_rd, "R4 scalar read on slice0", slice_scl_rd, 1);
      if (k == 1) chk(slice_valid && !slice_scl_rd, "R4 slice1 without scalar read", slice_scl_rd, 0);
      if (k == 5) chk(!wb_valid, "R4 slice0 writes nothing", wb_valid, 0);
      if (k == 6) chk(wb_valid && wb_idx == 1 && ret_wb_valid, "R4 final slice writes scalar", wb_idx, 1);
      adv();
    end
    flush(4);

    // R10: writeback retire and direct retire in one cycle
    for (int k = 0; k < 9; k++) begin
      idle();
      if (k == 0) offer(3, -1, 0, 0, 1, 0);
      if (k == 2) offer(4, -3, 0, 0, 0, 0);
      settle();
      if (k == 6) chk(ret_wb_valid && ret_wb_tag == 3 && ret_dir_valid && ret_dir_tag == 4,
                      "R10 dual retire", {ret_wb_valid, ret_dir_valid}, 3);
      adv();
    end
    flush(4);

    // R7/R11: full FIFO stalls, a drain cancels the stall in the same cycle
    for (int k = 0; k < 14; k++) begin
      idle();
      wr_ready = (k >= 8);
      if (k == 0) offer(5, 0, 1, 0, 0, 0);
      settle();
      if (k == 5) chk(!stall, "R7 no stall with room", stall, 0);
      if (k == 6) chk(stall, "R7 stall on full FIFO", stall, 1);
      if (k == 7) chk(stall && !iss_ready, "R7 stall blocks issue", iss_ready, 0);
      if (k == 8) chk(!stall && wb_valid && wb_idx == 0, "R11 drain before shift", stall, 0);
      adv();
    end
    flush(6);

    // R8/R9/R7: memory slice waits for its reply while FIFO drains
    for (int k = 0; k < 13; k++) begin
      idle();
      wr_ready = (k >= 6);
      mem_rsp = (k == 9);
      if (k == 0) offer(6, -1, 1, 0, 0, 0);
      if (k == 2) offer(7, -3, 0, 0, 0, 1);
      settle();
      if (k == 3) chk(!mem_req, "R8 no request before stage", mem_req, 0);
      if (k == 4) chk(mem_req && mem_req_tag == 7 && mem_req_idx == 0, "R8 request at stage", mem_req, 1);
      if (k == 5) chk(!mem_req, "R8 single request", mem_req, 0);
      if (k == 6) chk(stall && wb_valid && wb_tag == 6 && wb_idx == 0, "R7 drain during stall", wb_valid, 1);
      if (k == 8) chk(stall && !mem_req, "R9 held without reply", stall, 1);
      if (k == 9) chk(stall, "R9 stall in reply cycle", stall, 1);
      if (k == 10) chk(!stall && ret_dir_valid && ret_dir_tag == 7, "R9 release after reply", stall, 0);
      adv();
    end
    flush(4);

    // R3: non-pipelined mode waits for empty stages
    wait_empty = 1;
    for (int k = 0; k < 7; k++) begin
      idle();
      if (k == 0) offer(8, -3, 0, 0, 0, 0);
      settle();
      if (k == 1) chk(!iss_ready, "R3 wait for empty", iss_ready, 0);
      if (k == 4) chk(!iss_ready && ret_dir_valid, "R3 still occupied", iss_ready, 0);
      if (k == 5) chk(iss_ready, "R3 ready when empty", iss_ready, 1);
      adv();
    end
    wait_empty = 0;

    // R2: largest group gives sixteen slices, with a read hold
    cnt = 0;
    for (int k = 0; k < 22; k++) begin
      idle();
      if (k == 0) offer(9, 2, 1, 0, 0, 0);
      if (k == 3) rd_ready = 0;
      settle();
      if (slice_valid && slice_tag == 9) cnt++;
      adv();
    end
    chk(cnt == exp_slices(2), "R2 slice count", cnt, exp_slices(2));
    flush(8);

    // constrained random traffic
    auto_rsp = 1;
    for (int k = 0; k < 4000; k++) begin
      idle();
      if (k % 500 == 0) wait_empty = $urandom % 4 == 0;
      rd_ready = $urandom % 5 != 0;
      wr_ready = $urandom % 5 < 3;
      if ($urandom % 2 == 0)
        offer(k % 16, int'($urandom % 5) - 3, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 3 == 0);
      if (iss_valid && pend[iss_tag] != 0) iss_valid = 0;
      settle();
      adv();
    end
    wait_empty = 0;
    flush(80);
    chk(exp_q.size() == 0, "R6 all writebacks drained", exp_q.size(), 0);
    for (int i = 0; i < 16; i++) chk(pend[i] == 0, "R10 every instruction retired", pend[i], 0);
    chk(mem_seen == mem_exp, "R8 one request per memory slice", mem_seen, mem_exp);
    chk(outstanding == 0, "R9 all replies consumed", outstanding, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule